// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control and status registers of a processor core. Registers are selected by a 6-bit slot number. There is one read port and one write port, and they can be used in the same cycle. Every slot has its own policy: full-width storage, a keep-mask, forcing of particular bits, clear-on-any-write, or set-to-one. Slots are also readable-only, writable-only, both, or neither. An access that is not permitted in its direction returns a fault flag and does not return data.

Some slots are views rather than plain storage. The cycle-count slot joins a stored upper half with a counter that runs by itself. The staged page-entry slot returns its fields repacked, together with the current data address-space number. Writes to the invalidate and tag slots pulse strobes toward a translation buffer outside the block. A read of the virtual-address slot that is not speculative clears an interrupt-lock flag. While the speculative input is high, every write is dropped without a fault.

Top module: `ctl_reg_bank`

## Requirements
- R1: A synchronous reset clears every slot, the free-running counter, the read data, the interrupt lock and all fault and strobe outputs to zero.
- R2: rd_data_o and rd_fault_o change on the clock edge that samples rd_en_i and then hold while rd_en_i is low. A faulting read returns zero data. A read and a write to the same slot in one cycle return the value held before the write.
- R3: Writes keep only these bits: slots 17 and 18 keep bits 3:0; slot 19 keeps bits 4:0; slots 20 and 21 keep mask 0x18; slot 22 keeps 0x7FFF0; slot 23 keeps 0xFF_FFFF_0300; slots 24 and 25 keep bits 63:30; slots 26 and 27 keep bits 5:0; slot 28 keeps 0x7F0; slot 29 keeps bits 63:57.
- R4: A write to slot 16 (exception address) stores the value with bit 1 forced to zero.
- R5: Any write to slot 30 or slot 31 clears that slot to zero, whatever the data.
- R6: Writes to slots 32, 33 and 36 fault. Reads of slots 38 to 42 fault. Slots 43 and above fault in both directions. wr_fault_o pulses in the cycle after the write, and a faulting write changes nothing.
- R7: While spec_i is high, a write stores nothing, raises no fault (even to an illegal slot) and pulses no strobe.
- R8: A read of slot 34 returns the stored bits 63:32 joined with the low 32 bits of a counter that increments on every clock after reset. A write to slot 35 makes it read back as 1.
- R9: lock_set_i sets intr_lock_o on the next edge. A read of slot 36 with spec_i low clears it, unless lock_set_i is high in the same cycle, in which case set wins.
- R10: A read of slot 37 returns the stored bits 58:32, 15:8, 4, 2 and 1, with the other bits zero, ORed with bits 63:57 of slot 29.
- R11: Writes to slots 39 and 40 store zero and pulse flush_all_o and flush_proc_o respectively. A write to slot 41 pulses flush_one_o with flush_va_o equal to the data and flush_asn_o equal to bits 63:57 of slot 29.
- R12: A write to slot 38 pulses insert_o with insert_tag_o equal to the data and insert_entry_o equal to the slot-37 view of R10. If bits 6:5 of the staged slot-37 value are nonzero, gh_err_o pulses instead and nothing is inserted or stored.
- R13: Slots 0 to 15 are full 64-bit read/write scratch storage, independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_i | input | 1 | Access is speculative |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | IDX_W | Read slot number |
| rd_data_o | output | 64 | Read data, one cycle after request |
| rd_fault_o | output | 1 | Read was not permitted |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | IDX_W | Write slot number |
| wr_data_i | input | 64 | Write data |
| wr_fault_o | output | 1 | Write was not permitted |
| lock_set_i | input | 1 | Sets the interrupt lock |
| intr_lock_o | output | 1 | Interrupt lock flag |
| flush_all_o | output | 1 | Invalidate-all pulse |
| flush_proc_o | output | 1 | Invalidate-process pulse |
| flush_one_o | output | 1 | Invalidate-address pulse |
| flush_va_o | output | 64 | Address for flush_one_o |
| flush_asn_o | output | 7 | Address-space number for flush_one_o |
| insert_o | output | 1 | Insert-entry pulse |
| insert_tag_o | output | 64 | Tag for insert_o |
| insert_entry_o | output | 64 | Packed entry fields for insert_o |
| gh_err_o | output | 1 | Tag write refused for nonzero granularity hint |

## Verification
The bench builds the block with IDX_W = 6 and CNT_W = 32. A 6-bit slot number leaves slots 43 to 63 unassigned, so both-direction faults can be reached at the ports. A 32-bit counter makes the split of the cycle-count view land exactly at bit 32. With these values, every write policy, the repacked entry view with its ASN merge, the speculative drop and the strobe payloads can all be observed directly at the ports.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int XLEN     = 64;
  localparam int ASN_W    = 7;
  localparam int SCR_N    = 16;
  localparam int GH_LSB   = 5;
  localparam int GH_W     = 2;

  localparam int IX_EXC_ADDR  = 16;
  localparam int IX_AST_REQ   = 17;
  localparam int IX_AST_EN    = 18;
  localparam int IX_IPL       = 19;
  localparam int IX_IMODE     = 20;
  localparam int IX_DMODE     = 21;
  localparam int IX_SWI       = 22;
  localparam int IX_ICTL      = 23;
  localparam int IX_IPTB      = 24;
  localparam int IX_DPTB      = 25;
  localparam int IX_CMODE     = 26;
  localparam int IX_MMODE     = 27;
  localparam int IX_IASN      = 28;
  localparam int IX_DASN      = 29;
  localparam int IX_XSUM      = 30;
  localparam int IX_XMSK      = 31;
  localparam int IX_INTID     = 32;
  localparam int IX_MMSTAT    = 33;
  localparam int IX_CC        = 34;
  localparam int IX_CCCTL     = 35;
  localparam int IX_VA        = 36;
  localparam int IX_DPTE      = 37;
  localparam int IX_DTAG      = 38;
  localparam int IX_INV_ALL   = 39;
  localparam int IX_INV_PROC  = 40;
  localparam int IX_INV_ONE   = 41;
  localparam int IX_HWCLR     = 42;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    WK_BAD, WK_KEEP, WK_CLEAR, WK_SET1,
    WK_INV_ALL, WK_INV_PROC, WK_INV_ONE, WK_TAG
  } wkind_e;

  localparam word_t PTE_FIELDS = 64'h07FF_FFFF_0000_FF16;
  localparam word_t DASN_MASK  = 64'hFE00_0000_0000_0000;

  // Bits a plain write keeps, per slot
  function automatic word_t wr_mask(int ix);
    case (ix)
      IX_EXC_ADDR:          return ~64'h2;
      IX_AST_REQ, IX_AST_EN: return 64'hF;
      IX_IPL:               return 64'h1F;
      IX_IMODE, IX_DMODE:   return 64'h18;
      IX_SWI:               return 64'h7_FFF0;
      IX_ICTL:              return 64'hFF_FFFF_0300;
      IX_IPTB, IX_DPTB:     return 64'hFFFF_FFFF_C000_0000;
      IX_CMODE, IX_MMODE:   return 64'h3F;
      IX_IASN:              return 64'h7F0;
      IX_DASN:              return DASN_MASK;
      default:              return '1;
    endcase
  endfunction

  // Write policy per slot; WK_BAD means the write faults
  function automatic wkind_e wr_kind(int ix);
    if (ix < SCR_N) return WK_KEEP;
    case (ix)
      IX_EXC_ADDR, IX_AST_REQ, IX_AST_EN, IX_IPL, IX_IMODE, IX_DMODE,
      IX_SWI, IX_ICTL, IX_IPTB, IX_DPTB, IX_CMODE, IX_MMODE, IX_IASN,
      IX_DASN, IX_CC, IX_DPTE, IX_HWCLR: return WK_KEEP;
      IX_XSUM, IX_XMSK:   return WK_CLEAR;
      IX_CCCTL:           return WK_SET1;
      IX_INV_ALL:         return WK_INV_ALL;
      IX_INV_PROC:        return WK_INV_PROC;
      IX_INV_ONE:         return WK_INV_ONE;
      IX_DTAG:            return WK_TAG;
      default:            return WK_BAD;
    endcase
  endfunction

  // Slots 0..37 are readable; 38..42 write-only; above that unassigned
  function automatic logic rd_ok(int ix);
    return ix <= IX_DPTE;
  endfunction
endpackage

// File: rtl/ctl_cycle_cnt.sv
module ctl_cycle_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ctl_wr_dec.sv
module ctl_wr_dec
  import ctl_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             en_i,
  input  logic             spec_i,
  input  logic [IDX_W-1:0] idx_i,
  input  word_t            data_i,
  input  logic [GH_W-1:0]  gh_i,
  output logic             store_o,
  output word_t            val_o,
  output logic             fault_o,
  output logic             inv_all_o,
  output logic             inv_proc_o,
  output logic             inv_one_o,
  output logic             ins_o,
  output logic             gh_err_o
);
  int     ix;
  wkind_e kind;
  logic   act;

  always_comb begin
    ix         = 32'(idx_i);
    kind       = wr_kind(ix);
    act        = en_i && !spec_i;
    store_o    = 1'b0;
    val_o      = '0;
    fault_o    = 1'b0;
    inv_all_o  = 1'b0;
    inv_proc_o = 1'b0;
    inv_one_o  = 1'b0;
    ins_o      = 1'b0;
    gh_err_o   = 1'b0;
    if (act) begin
      case (kind)
        WK_BAD:   fault_o = 1'b1;
        WK_KEEP: begin
          store_o = 1'b1;
          val_o   = data_i & wr_mask(ix);
        end
        WK_CLEAR: store_o = 1'b1;
        WK_SET1: begin
          store_o = 1'b1;
          val_o   = word_t'(1);
        end
        WK_INV_ALL: begin
          store_o   = 1'b1;
          inv_all_o = 1'b1;
        end
        WK_INV_PROC: begin
          store_o    = 1'b1;
          inv_proc_o = 1'b1;
        end
        WK_INV_ONE: begin
          store_o   = 1'b1;
          val_o     = data_i;
          inv_one_o = 1'b1;
        end
        WK_TAG: begin
          if (gh_i != '0) gh_err_o = 1'b1;
          else begin
            store_o = 1'b1;
            val_o   = data_i;
            ins_o   = 1'b1;
          end
        end
        default: fault_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ctl_rd_mux.sv
module ctl_rd_mux
  import ctl_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 32
) (
  input  logic [IDX_W-1:0] idx_i,
  input  word_t            slot_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  word_t            pte_view_i,
  output word_t            val_o,
  output logic             fault_o,
  output logic             va_hit_o
);
  int   ix;
  logic ok;

  always_comb begin
    ix       = 32'(idx_i);
    ok       = rd_ok(ix);
    fault_o  = !ok;
    va_hit_o = ok && (ix == IX_VA);
    case (ix)
      IX_CC:   val_o = {slot_i[XLEN-1:CNT_W], cnt_i};
      IX_DPTE: val_o = pte_view_i;
      default: val_o = slot_i;
    endcase
    if (!ok) val_o = '0;
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spec_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [63:0]      rd_data_o,
  output logic             rd_fault_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [63:0]      wr_data_i,
  output logic             wr_fault_o,
  input  logic             lock_set_i,
  output logic             intr_lock_o,
  output logic             flush_all_o,
  output logic             flush_proc_o,
  output logic             flush_one_o,
  output logic [63:0]      flush_va_o,
  output logic [6:0]       flush_asn_o,
  output logic             insert_o,
  output logic [63:0]      insert_tag_o,
  output logic [63:0]      insert_entry_o,
  output logic             gh_err_o
);
  localparam int NREG = 1 << IDX_W;

  word_t            bank [NREG];
  logic [CNT_W-1:0] cnt;
  word_t            pte_view;

  logic  w_store, w_fault, w_all, w_proc, w_one, w_ins, w_gh;
  word_t w_val;
  word_t r_val;
  logic  r_fault, r_va;

  assign pte_view = (bank[IX_DPTE] & PTE_FIELDS) | (bank[IX_DASN] & DASN_MASK);

  ctl_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  ctl_wr_dec #(.IDX_W(IDX_W)) u_wdec (
    .en_i       (wr_en_i),
    .spec_i     (spec_i),
    .idx_i      (wr_idx_i),
    .data_i     (wr_data_i),
    .gh_i       (bank[IX_DPTE][GH_LSB +: GH_W]),
    .store_o    (w_store),
    .val_o      (w_val),
    .fault_o    (w_fault),
    .inv_all_o  (w_all),
    .inv_proc_o (w_proc),
    .inv_one_o  (w_one),
    .ins_o      (w_ins),
    .gh_err_o   (w_gh)
  );

  ctl_rd_mux #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_rmux (
    .idx_i      (rd_idx_i),
    .slot_i     (bank[rd_idx_i]),
    .cnt_i      (cnt),
    .pte_view_i (pte_view),
    .val_o      (r_val),
    .fault_o    (r_fault),
    .va_hit_o   (r_va)
  );

  // Slot storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (w_store) begin
      bank[wr_idx_i] <= w_val;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_fault_o <= 1'b0;
    end else begin
      rd_fault_o <= rd_en_i && r_fault;
      if (rd_en_i) rd_data_o <= r_val;
    end
  end

  // Interrupt lock: set has priority over the clearing read
  always_ff @(posedge clk) begin
    if (rst)                              intr_lock_o <= 1'b0;
    else if (lock_set_i)                  intr_lock_o <= 1'b1;
    else if (rd_en_i && !spec_i && r_va)  intr_lock_o <= 1'b0;
  end

  // Write-side pulses and payloads
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_fault_o     <= 1'b0;
      flush_all_o    <= 1'b0;
      flush_proc_o   <= 1'b0;
      flush_one_o    <= 1'b0;
      flush_va_o     <= '0;
      flush_asn_o    <= '0;
      insert_o       <= 1'b0;
      insert_tag_o   <= '0;
      insert_entry_o <= '0;
      gh_err_o       <= 1'b0;
    end else begin
      wr_fault_o   <= w_fault;
      flush_all_o  <= w_all;
      flush_proc_o <= w_proc;
      flush_one_o  <= w_one;
      insert_o     <= w_ins;
      gh_err_o     <= w_gh;
      if (w_one) begin
        flush_va_o  <= wr_data_i;
        flush_asn_o <= bank[IX_DASN][XLEN-1 -: ASN_W];
      end
      if (w_ins) begin
        insert_tag_o   <= wr_data_i;
        insert_entry_o <= pte_view;
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk
  import ctl_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             spec_i,
  input logic             rd_en_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [63:0]      rd_data_o,
  input logic             rd_fault_o,
  input logic             wr_en_i,
  input logic             wr_fault_o,
  input logic             lock_set_i,
  input logic             intr_lock_o,
  input logic             flush_all_o,
  input logic             flush_proc_o,
  input logic             flush_one_o,
  input logic             insert_o,
  input logic             gh_err_o
);
  a_r2_fault_zero_data: assert property (@(posedge clk) disable iff (rst)
    rd_fault_o |-> rd_data_o == '0);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o) && !rd_fault_o);

  a_r3_ipl_width: assert property (@(posedge clk) disable iff (rst)
    rd_en_i && rd_idx_i == IDX_W'(IX_IPL) |=> rd_data_o[63:5] == '0);

  a_r4_exc_bit1_low: assert property (@(posedge clk) disable iff (rst)
    rd_en_i && rd_idx_i == IDX_W'(IX_EXC_ADDR) |=> !rd_fault_o && !rd_data_o[1]);

  a_r6_no_fault_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> !wr_fault_o);

  a_r7_spec_silent: assert property (@(posedge clk) disable iff (rst)
    spec_i && wr_en_i |=> !wr_fault_o && !flush_all_o && !flush_proc_o
                          && !flush_one_o && !insert_o && !gh_err_o);

  a_r9_lock_set: assert property (@(posedge clk) disable iff (rst)
    lock_set_i |=> intr_lock_o);

  a_r9_va_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_en_i && !spec_i && !lock_set_i && rd_idx_i == IDX_W'(IX_VA) |=> !intr_lock_o);

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flush_all_o, flush_proc_o, flush_one_o, insert_o, gh_err_o}));
endmodule

bind ctl_reg_bank ctl_reg_bank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .spec_i       (spec_i),
  .rd_en_i      (rd_en_i),
  .rd_idx_i     (rd_idx_i),
  .rd_data_o    (rd_data_o),
  .rd_fault_o   (rd_fault_o),
  .wr_en_i      (wr_en_i),
  .wr_fault_o   (wr_fault_o),
  .lock_set_i   (lock_set_i),
  .intr_lock_o  (intr_lock_o),
  .flush_all_o  (flush_all_o),
  .flush_proc_o (flush_proc_o),
  .flush_one_o  (flush_one_o),
  .insert_o     (insert_o),
  .gh_err_o     (gh_err_o)
);

// File: tb/ctl_reg_bank_bench.sv
module ctl_reg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;
  localparam int CNT_W      = 32;
  localparam int NV         = 22;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             spec_i = 1'b0;
  logic             rd_en_i = 1'b0;
  logic [IDX_W-1:0] rd_idx_i = '0;
  logic [63:0]      rd_data_o;
  logic             rd_fault_o;
  logic             wr_en_i = 1'b0;
  logic [IDX_W-1:0] wr_idx_i = '0;
  logic [63:0]      wr_data_i = '0;
  logic             wr_fault_o;
  logic             lock_set_i = 1'b0;
  logic             intr_lock_o;
  logic             flush_all_o, flush_proc_o, flush_one_o;
  logic [63:0]      flush_va_o;
  logic [6:0]       flush_asn_o;
  logic             insert_o;
  logic [63:0]      insert_tag_o, insert_entry_o;
  logic             gh_err_o;

  ctl_reg_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctl_reg_bank (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  // Sampled write-side results
  logic s_wf, s_all, s_proc, s_one, s_ins, s_gh;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(int ix, logic [63:0] v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = IDX_W'(ix); wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
    s_wf = wr_fault_o; s_all = flush_all_o; s_proc = flush_proc_o;
    s_one = flush_one_o; s_ins = insert_o; s_gh = gh_err_o;
  endtask

  task automatic rd(int ix);
    @(negedge clk);
    rd_en_i = 1'b1; rd_idx_i = IDX_W'(ix);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  // {slot, write value, expected read-back}
  localparam logic [133:0] VEC [NV] = '{
    {6'd0,  64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},   // R13
    {6'd15, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210},   // R13
    {6'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD},   // R4
    {6'd17, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_000F},   // R3
    {6'd18, 64'h0000_0000_0000_00A5, 64'h0000_0000_0000_0005},   // R3
    {6'd19, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_001F},   // R3
    {6'd20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0018},   // R3
    {6'd21, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008},   // R3
    {6'd22, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0007_FFF0},   // R3
    {6'd23, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00FF_FFFF_0300},   // R3
    {6'd24, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_C000_0000},   // R3
    {6'd25, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_8000_0000},   // R3
    {6'd26, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_003F},   // R3
    {6'd27, 64'h0000_0000_0000_0041, 64'h0000_0000_0000_0001},   // R3
    {6'd28, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_07F0},   // R3
    {6'd29, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFE00_0000_0000_0000},   // R3
    {6'd30, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},   // R5
    {6'd31, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},   // R5
    {6'd35, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001},   // R8
    {6'd16, 64'h0000_0000_0000_0006, 64'h0000_0000_0000_0004},   // R4
    {6'd17, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0000},   // R3
    {6'd0,  64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000}    // R13
  };

  logic [31:0] lo_a;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rd_data", rd_data_o, '0);
    chk("R1 lock", 64'(intr_lock_o), '0);
    chk("R1 strobes", 64'({wr_fault_o, flush_all_o, flush_proc_o, flush_one_o,
                           insert_o, gh_err_o}), '0);
    rd(34);
    chk("R1 counter from zero", rd_data_o, 64'h1);
    rd(5);
    chk("R1 scratch cleared", rd_data_o, '0);

    // Table walk: write, check no fault, read back
    for (int i = 0; i < NV; i++) begin
      wr(int'(VEC[i][133:128]), VEC[i][127:64]);
      chk("R3 table write fault", 64'(s_wf), '0);
      rd(int'(VEC[i][133:128]));
      chk("R3 table readback", rd_data_o, VEC[i][63:0]);
      chk("R2 table rd fault", 64'(rd_fault_o), '0);
    end

    // R2: read and write of same slot in one cycle sees old value
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 6'd7; wr_data_i = 64'hAAAA_5555_AAAA_5555;
    rd_en_i = 1'b1; rd_idx_i = 6'd7;
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk("R2 read-during-write old value", rd_data_o, '0);
    @(negedge clk);
    chk("R2 data held while idle", rd_data_o, '0);
    rd(7);
    chk("R2 new value after write", rd_data_o, 64'hAAAA_5555_AAAA_5555);

    // R6: directional faults
    wr(32, 64'h1);
    chk("R6 write read-only 32", 64'(s_wf), 64'h1);
    wr(36, 64'h1);
    chk("R6 write read-only 36", 64'(s_wf), 64'h1);
    rd(32);
    chk("R6 read read-only ok", 64'(rd_fault_o), '0);
    chk("R6 read-only unchanged", rd_data_o, '0);
    rd(40);
    chk("R6 read write-only fault", 64'(rd_fault_o), 64'h1);
    chk("R2 fault zero data", rd_data_o, '0);
    rd(42);
    chk("R6 read write-only 42", 64'(rd_fault_o), 64'h1);
    wr(50, 64'h9);
    chk("R6 unknown write fault", 64'(s_wf), 64'h1);
    rd(63);
    chk("R6 unknown read fault", 64'(rd_fault_o), 64'h1);
    wr(42, 64'h3);
    chk("R6 write-only accepts write", 64'(s_wf), '0);

    // R7: speculative writes dropped silently
    spec_i = 1'b1;
    wr(9, 64'h1111_2222_3333_4444);
    chk("R7 spec no fault", 64'(s_wf), '0);
    wr(50, 64'h1);
    chk("R7 spec illegal no fault", 64'(s_wf), '0);
    wr(39, 64'h1);
    chk("R7 spec no strobe", 64'(s_all), '0);
    spec_i = 1'b0;
    rd(9);
    chk("R7 spec write not stored", rd_data_o, '0);

    // R8: cycle-count view
    wr(34, 64'hDEAD_BEEF_1234_5678);
    rd(34);
    chk("R8 upper stored", 64'(rd_data_o[63:32]), 64'hDEAD_BEEF);
    lo_a = rd_data_o[31:0];
    rd(34);
    chk("R8 counter advances", 64'(rd_data_o[31:0] - lo_a), 64'h2);

    // R9: interrupt lock
    @(negedge clk); lock_set_i = 1'b1;
    @(negedge clk); lock_set_i = 1'b0;
    chk("R9 lock set", 64'(intr_lock_o), 64'h1);
    spec_i = 1'b1;
    rd(36);
    spec_i = 1'b0;
    chk("R9 speculative read keeps lock", 64'(intr_lock_o), 64'h1);
    @(negedge clk);
    rd_en_i = 1'b1; rd_idx_i = 6'd36; lock_set_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0; lock_set_i = 1'b0;
    chk("R9 set wins over clear", 64'(intr_lock_o), 64'h1);
    rd(36);
    chk("R9 read clears lock", 64'(intr_lock_o), '0);

    // R10: packed entry view with ASN 0x2A
    wr(29, 64'h5400_0000_0000_0000);
    wr(37, 64'h0123_4567_00F0_A517);
    rd(37);
    chk("R10 packed entry", rd_data_o, 64'h5523_4567_0000_A516);

    // R11: invalidate strobes
    wr(41, 64'h0000_0000_0000_1000);
    chk("R11 flush one", 64'(s_one), 64'h1);
    chk("R11 flush va", flush_va_o, 64'h1000);
    chk("R11 flush asn", 64'(flush_asn_o), 64'h2A);
    wr(39, 64'hFFFF);
    chk("R11 flush all", 64'({s_all, s_proc, s_one}), 64'h4);
    wr(40, 64'hFFFF);
    chk("R11 flush proc", 64'({s_all, s_proc, s_one}), 64'h2);

    // R12: tag insert and granularity-hint refusal
    wr(38, 64'h0000_0000_CAFE_0000);
    chk("R12 insert pulse", 64'({s_ins, s_gh}), 64'h2);
    chk("R12 insert tag", insert_tag_o, 64'hCAFE_0000);
    chk("R12 insert entry", insert_entry_o, 64'h5523_4567_0000_A516);
    wr(37, 64'h0000_0000_0000_0020);
    wr(38, 64'h0000_0000_BEEF_0000);
    chk("R12 gh error", 64'({s_ins, s_gh}), 64'h1);
    chk("R12 tag kept", insert_tag_o, 64'hCAFE_0000);
    rd(38);
    chk("R12 tag write-only", 64'(rd_fault_o), 64'h1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule